// File: doc/BRIEF.md
# Extended-Mode Register Port Decoder for a Local Interrupt Controller

This block sits between a register-port access path and the register file of a local interrupt controller that runs in its extended mode. Each access presents a 12-bit port address, a 64-bit write word and a read or a write strobe. The block turns the address into a register selection, checks the access against the rules of that register, and either performs it or reports a general-protection fault. One clock after the strobe it returns a response. A successful read gives valid data. A failing read or write gives a fault flag.

The port address space is a compressed form of the memory-mapped layout. A 32-bit register at memory offset M, aligned on 16 bytes, sits at port address `BASE + (M >> 4)`, with a default `BASE` of 800h. The block holds the task-priority, error-status, command and local-vector-table registers. The identifier, version, logical-destination, in-service and trigger-mode views are read-only and are built from inputs. A write to the self-interrupt port produces a one-cycle request that carries its vector. Prioritisation and delivery of interrupts belong to other blocks.

Top module: `xmode_reg_port`

## Requirements
- R1: After reset no response or self request is pending. The task-priority, command and error-status registers read zero. Every local-vector-table entry reads 0001_0000h, which means masked.
- R2: A read of offset 02h (port address BASE+02h) returns `core_id` in bits 31:0.
- R3: An access faults if its address lies outside BASE..BASE+FFh, or if its offset in that range is not assigned. The unassigned offsets include 0Eh, where the destination-format register would sit, and 20h–27h.
- R4: Every register except the command register returns zero in bits 63:32. A write to such a register with bits 63:32 nonzero faults.
- R5: The command register at offset 30h is a 64-bit read/write register. Bit 12 always reads zero. All other bits read back as written.
- R6: Offset 3Fh is a write-only self-interrupt port. A write with bits 63:8 zero pulses `self_req` for one cycle, one cycle later, with `self_vec` equal to bits 7:0. A read faults. A write with any of bits 63:8 set faults.
- R7: A write to any of the identifier (02h), version (03h), logical-destination (0Dh), in-service (10h–17h) or trigger-mode (18h–1Fh) offsets faults.
- R8: Offset 0Dh reads as `{core_id[19:4], 16'h0001 << core_id[3:0]}`.
- R9: In-service offset 10h+k and trigger-mode offset 18h+k (k = 0..7) return bits 32k+31:32k of `isr_vec` and of `tmr_vec` respectively.
- R10: Task priority (08h) keeps write bits 7:0 and reads zero in bits 31:8. The six local-vector-table entries at 32h–37h each hold 32 bits independently.
- R11: Offset 03h reads `{7'b0, DEOI_SUP, 8'(NUM_LVT-1), 8'h00, VERSION}`, so bit 24 reports directed-EOI support.
- R12: Error status (28h, bits 7:0) ORs in `err_log` on every clock. A write of zero clears the previous contents, but a bit arriving in the same cycle is kept. A nonzero write faults.
- R13: A fault leaves every register unchanged and produces no `self_req`. Strobing read and write together always faults.
- R14: Each strobe gets a response in the following cycle. `rsp_valid` and `rsp_fault` are never high together. `rsp_data` is zero whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (12) | Port address |
| wdata | input | 64 | Write data |
| core_id | input | 32 | Local identifier of this controller |
| isr_vec | input | 256 | In-service bits, one per vector |
| tmr_vec | input | 256 | Trigger-mode bits, one per vector |
| err_log | input | 8 | Error bits to record this cycle |
| rsp_valid | output | 1 | Read completed, `rsp_data` valid |
| rsp_fault | output | 1 | Previous access faulted |
| rsp_data | output | 64 | Read data |
| self_req | output | 1 | Self-interrupt request pulse |
| self_vec | output | 8 | Vector of the self-interrupt request |

## Verification
Two functions can meet on the same clock edge: logging a new error bit into the error-status register, and a software write of zero that clears it. The bench drives `err_log` in the very cycle of a clearing write. A following read must show only the newly arrived bit: the older bits are cleared and the fresh one survives. The same bench also pairs a read and a write strobe in one cycle, and a faulting write with a later read-back, to confirm that the fault blocks the update.

// File: rtl/xmode_reg_pkg.sv
package xmode_reg_pkg;

    localparam int DATA_W  = 64;
    localparam int HALF_W  = 32;
    localparam int VEC_N   = 256;
    localparam int SLICE_N = VEC_N / HALF_W;
    localparam int SUB_W   = $clog2(SLICE_N);
    localparam int NUM_LVT = 6;
    localparam int TPR_W   = 8;
    localparam int ESR_W   = 8;
    localparam int SPAN_W  = 8;
    localparam int ICR_DS_BIT = 12;

    localparam logic [SPAN_W-1:0] OFF_ID   = 8'h02;
    localparam logic [SPAN_W-1:0] OFF_VER  = 8'h03;
    localparam logic [SPAN_W-1:0] OFF_TPR  = 8'h08;
    localparam logic [SPAN_W-1:0] OFF_LDR  = 8'h0D;
    localparam logic [SPAN_W-1:0] OFF_ISR  = 8'h10;
    localparam logic [SPAN_W-1:0] OFF_TMR  = 8'h18;
    localparam logic [SPAN_W-1:0] OFF_ESR  = 8'h28;
    localparam logic [SPAN_W-1:0] OFF_ICR  = 8'h30;
    localparam logic [SPAN_W-1:0] OFF_LVT  = 8'h32;
    localparam logic [SPAN_W-1:0] OFF_SELF = 8'h3F;

    localparam logic [HALF_W-1:0] LVT_RESET = 32'h0001_0000;

    typedef enum logic [3:0] {
        RK_NONE, RK_ID, RK_VER, RK_TPR, RK_LDR, RK_ISR,
        RK_TMR, RK_ESR, RK_ICR, RK_LVT, RK_SELF
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [SUB_W-1:0] sub;
    } reg_sel_t;

    function automatic reg_sel_t map_offset(input logic [SPAN_W-1:0] off);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.sub  = '0;
        if (off == OFF_ID)        s.kind = RK_ID;
        else if (off == OFF_VER)  s.kind = RK_VER;
        else if (off == OFF_TPR)  s.kind = RK_TPR;
        else if (off == OFF_LDR)  s.kind = RK_LDR;
        else if (off == OFF_ESR)  s.kind = RK_ESR;
        else if (off == OFF_ICR)  s.kind = RK_ICR;
        else if (off == OFF_SELF) s.kind = RK_SELF;
        else if (off >= OFF_ISR && off < OFF_ISR + SPAN_W'(SLICE_N)) begin
            s.kind = RK_ISR;
            s.sub  = SUB_W'(off - OFF_ISR);
        end else if (off >= OFF_TMR && off < OFF_TMR + SPAN_W'(SLICE_N)) begin
            s.kind = RK_TMR;
            s.sub  = SUB_W'(off - OFF_TMR);
        end else if (off >= OFF_LVT && off < OFF_LVT + SPAN_W'(NUM_LVT)) begin
            s.kind = RK_LVT;
            s.sub  = SUB_W'(off - OFF_LVT);
        end
        return s;
    endfunction

    // Cluster number from id[19:4] in the upper half, one-hot member bit below.
    function automatic logic [HALF_W-1:0] ldr_from_id(input logic [HALF_W-1:0] id);
        return {id[19:4], 16'h0001 << id[3:0]};
    endfunction

endpackage

// File: rtl/xmode_addr_decode.sv
module xmode_addr_decode
    import xmode_reg_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE   = 12'h800
) (
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output reg_sel_t          sel,
    output logic              fault
);

    logic [ADDR_W-1:0] diff;
    logic              in_range;
    logic              hi_set;
    logic              bad;

    assign diff     = addr - BASE;
    assign in_range = (addr >= BASE) && (diff[ADDR_W-1:SPAN_W] == '0);
    assign hi_set   = |wdata[DATA_W-1:HALF_W];

    always_comb begin
        if (in_range) sel = map_offset(diff[SPAN_W-1:0]);
        else          sel = '{kind: RK_NONE, sub: '0};
    end

    always_comb begin
        unique case (sel.kind)
            RK_ID, RK_VER, RK_LDR, RK_ISR, RK_TMR: bad = wr_en;
            RK_TPR, RK_LVT: bad = wr_en && hi_set;
            RK_ESR:         bad = wr_en && (wdata != '0);
            RK_ICR:         bad = 1'b0;
            RK_SELF:        bad = rd_en || (wr_en && (wdata[DATA_W-1:8] != '0));
            default:        bad = 1'b1;
        endcase
    end

    assign fault = (rd_en && wr_en) || ((rd_en || wr_en) && bad);

endmodule

// File: rtl/xmode_reg_store.sv
module xmode_reg_store
    import xmode_reg_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_ok,
    input  reg_sel_t                         sel,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [ESR_W-1:0]                 err_log,
    output logic [TPR_W-1:0]                 tpr_q,
    output logic [ESR_W-1:0]                 esr_q,
    output logic [DATA_W-1:0]                icr_q,
    output logic [NUM_LVT-1:0][HALF_W-1:0]   lvt_q
);

    logic esr_clr;
    assign esr_clr = wr_ok && (sel.kind == RK_ESR);

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q <= '0;
            esr_q <= '0;
            icr_q <= '0;
        end else begin
            esr_q <= (esr_clr ? '0 : esr_q) | err_log;
            if (wr_ok && sel.kind == RK_TPR) tpr_q <= wdata[TPR_W-1:0];
            if (wr_ok && sel.kind == RK_ICR) begin
                icr_q             <= wdata;
                icr_q[ICR_DS_BIT] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NUM_LVT; g++) begin : g_lvt
        logic [HALF_W-1:0] entry_q;
        always_ff @(posedge clk) begin
            if (rst)
                entry_q <= LVT_RESET;
            else if (wr_ok && sel.kind == RK_LVT && sel.sub == SUB_W'(g))
                entry_q <= wdata[HALF_W-1:0];
        end
        assign lvt_q[g] = entry_q;
    end

endmodule

// File: rtl/xmode_read_mux.sv
module xmode_read_mux
    import xmode_reg_pkg::*;
#(
    parameter logic       DEOI_SUP = 1'b1,
    parameter logic [7:0] VERSION  = 8'h15
) (
    input  reg_sel_t                         sel,
    input  logic [HALF_W-1:0]                core_id,
    input  logic [VEC_N-1:0]                 isr_vec,
    input  logic [VEC_N-1:0]                 tmr_vec,
    input  logic [TPR_W-1:0]                 tpr_q,
    input  logic [ESR_W-1:0]                 esr_q,
    input  logic [DATA_W-1:0]                icr_q,
    input  logic [NUM_LVT-1:0][HALF_W-1:0]   lvt_q,
    output logic [DATA_W-1:0]                rdata
);

    localparam logic [HALF_W-1:0] VER_WORD =
        {7'b0, DEOI_SUP, 8'(NUM_LVT - 1), 8'h00, VERSION};

    logic [HALF_W-1:0] low;

    always_comb begin
        low = '0;
        unique case (sel.kind)
            RK_ID:  low = core_id;
            RK_VER: low = VER_WORD;
            RK_TPR: low = HALF_W'(tpr_q);
            RK_LDR: low = ldr_from_id(core_id);
            RK_ISR: low = isr_vec[HALF_W*int'(sel.sub) +: HALF_W];
            RK_TMR: low = tmr_vec[HALF_W*int'(sel.sub) +: HALF_W];
            RK_ESR: low = HALF_W'(esr_q);
            RK_LVT: if (int'(sel.sub) < NUM_LVT) low = lvt_q[sel.sub];
            default: low = '0;
        endcase
    end

    assign rdata = (sel.kind == RK_ICR) ? icr_q : {{HALF_W{1'b0}}, low};

endmodule

// File: rtl/xmode_reg_port.sv
module xmode_reg_port
    import xmode_reg_pkg::*;
#(
    parameter int                ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] BASE     = 12'h800,
    parameter logic              DEOI_SUP = 1'b1,
    parameter logic [7:0]        VERSION  = 8'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       wdata,
    input  logic [31:0]       core_id,
    input  logic [255:0]      isr_vec,
    input  logic [255:0]      tmr_vec,
    input  logic [7:0]        err_log,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [63:0]       rsp_data,
    output logic              self_req,
    output logic [7:0]        self_vec
);

    reg_sel_t                        sel;
    logic                            fault;
    logic                            wr_ok;
    logic [TPR_W-1:0]                tpr_q;
    logic [ESR_W-1:0]                esr_q;
    logic [DATA_W-1:0]               icr_q;
    logic [NUM_LVT-1:0][HALF_W-1:0]  lvt_q;
    logic [DATA_W-1:0]               rdata;

    xmode_addr_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .sel(sel), .fault(fault)
    );

    assign wr_ok = wr_en && !fault;

    xmode_reg_store u_store (
        .clk(clk), .rst(rst), .wr_ok(wr_ok), .sel(sel), .wdata(wdata),
        .err_log(err_log), .tpr_q(tpr_q), .esr_q(esr_q), .icr_q(icr_q),
        .lvt_q(lvt_q)
    );

    xmode_read_mux #(.DEOI_SUP(DEOI_SUP), .VERSION(VERSION)) u_mux (
        .sel(sel), .core_id(core_id), .isr_vec(isr_vec), .tmr_vec(tmr_vec),
        .tpr_q(tpr_q), .esr_q(esr_q), .icr_q(icr_q), .lvt_q(lvt_q),
        .rdata(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_data  <= '0;
            self_req  <= 1'b0;
            self_vec  <= '0;
        end else begin
            rsp_valid <= rd_en && !fault;
            rsp_fault <= (rd_en || wr_en) && fault;
            rsp_data  <= (rd_en && !fault) ? rdata : '0;
            self_req  <= wr_ok && (sel.kind == RK_SELF);
            if (wr_ok && sel.kind == RK_SELF) self_vec <= wdata[7:0];
        end
    end

endmodule

// File: rtl/xmode_reg_port_chk.sv
module xmode_reg_port_chk #(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] BASE   = 12'h800
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [63:0]       wdata,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [63:0]       rsp_data,
    input logic              self_req
);

    localparam logic [ADDR_W-1:0] A_ID   = BASE + ADDR_W'(8'h02);
    localparam logic [ADDR_W-1:0] A_ICR  = BASE + ADDR_W'(8'h30);
    localparam logic [ADDR_W-1:0] A_SELF = BASE + ADDR_W'(8'h3F);

    p_excl_r14: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_fault));

    p_valid_from_read_r14: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(rd_en && !wr_en));

    p_data_idle_zero_r14: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> rsp_data == 64'h0);

    p_fault_from_access_r13: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> $past(rd_en || wr_en));

    p_both_strobes_fault_r13: assert property (@(posedge clk) disable iff (rst)
        rd_en && wr_en |=> rsp_fault);

    p_self_cause_r6: assert property (@(posedge clk) disable iff (rst)
        self_req |-> $past(wr_en && !rd_en && addr == A_SELF && wdata[63:8] == 56'h0));

    p_self_no_fault_r13: assert property (@(posedge clk) disable iff (rst)
        self_req |-> !rsp_fault);

    p_self_read_faults_r6: assert property (@(posedge clk) disable iff (rst)
        rd_en && addr == A_SELF |=> rsp_fault);

    p_ds_zero_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(addr) == A_ICR |-> !rsp_data[12]);

    p_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && $past(addr) != A_ICR |-> rsp_data[63:32] == 32'h0);

    p_id_write_faults_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && addr == A_ID |=> rsp_fault);

endmodule

bind xmode_reg_port xmode_reg_port_chk #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_data(rsp_data), .self_req(self_req)
);

// File: tb/xmode_reg_port_tb.sv
module xmode_reg_port_tb;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_en = 1'b0, wr_en = 1'b0;
    logic [11:0]  addr = '0;
    logic [63:0]  wdata = '0;
    logic [31:0]  core_id = 32'h0003_A7C5;
    logic [255:0] isr_vec, tmr_vec;
    logic [7:0]   err_log = '0;
    logic         rsp_valid, rsp_fault, self_req;
    logic [63:0]  rsp_data;
    logic [7:0]   self_vec;

    always #5 clk = ~clk;

    xmode_reg_port u_dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .core_id(core_id), .isr_vec(isr_vec), .tmr_vec(tmr_vec),
        .err_log(err_log), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_data(rsp_data), .self_req(self_req), .self_vec(self_vec)
    );

    // behavioural model state
    int          n_chk = 0, n_fail = 0;
    logic [7:0]  m_tpr = 0, m_esr = 0;
    logic [63:0] m_icr = 0;
    logic [31:0] m_lvt [6];
    bit          e_valid = 0, e_fault = 0, e_self = 0;
    logic [63:0] e_data = 0;
    logic [7:0]  e_vec = 0;
    string       e_tag = "R1";
    bit          finished = 0;

    function automatic bit m_fault(bit rd, bit wr, logic [11:0] a, logic [63:0] d);
        int o;
        if (rd && wr) return 1;
        if (!rd && !wr) return 0;
        if (a < 12'h800 || a > 12'h8FF) return 1;
        o = int'(a) - 'h800;
        if (o == 2 || o == 3 || o == 'hD || (o >= 'h10 && o <= 'h1F)) return wr;
        if (o == 8 || (o >= 'h32 && o <= 'h37)) return wr && d[63:32] != 0;
        if (o == 'h28) return wr && d != 0;
        if (o == 'h30) return 0;
        if (o == 'h3F) return rd || d[63:8] != 0;
        return 1;
    endfunction

    function automatic logic [63:0] m_read(logic [11:0] a);
        int o;
        o = int'(a) - 'h800;
        if (o == 2) return {32'h0, core_id};
        if (o == 3) return {32'h0, 7'h0, 1'b1, 8'd5, 8'h00, 8'h15};
        if (o == 8) return {56'h0, m_tpr};
        if (o == 'hD) return {32'h0, core_id[19:4], 16'h0001 << core_id[3:0]};
        if (o >= 'h10 && o <= 'h17) return {32'h0, isr_vec[32*(o-'h10) +: 32]};
        if (o >= 'h18 && o <= 'h1F) return {32'h0, tmr_vec[32*(o-'h18) +: 32]};
        if (o == 'h28) return {56'h0, m_esr};
        if (o == 'h30) return m_icr;
        if (o >= 'h32 && o <= 'h37) return {32'h0, m_lvt[o-'h32]};
        return 64'h0;
    endfunction

    task automatic check_prev();
        n_chk++;
        if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_data !== e_data ||
            self_req !== e_self || (e_self && self_vec !== e_vec)) begin
            n_fail++;
            $display("FAIL %s: got v=%0b f=%0b d=%h s=%0b sv=%h, expected v=%0b f=%0b d=%h s=%0b sv=%h",
                     e_tag, rsp_valid, rsp_fault, rsp_data, self_req, self_vec,
                     e_valid, e_fault, e_data, e_self, e_vec);
        end
    endtask

    task automatic step(string tag, bit rd, bit wr, logic [11:0] a, logic [63:0] d,
                        logic [7:0] el = 8'h0);
        bit bad, ok;
        @(negedge clk);
        check_prev();
        rd_en = rd; wr_en = wr; addr = a; wdata = d; err_log = el;
        bad = m_fault(rd, wr, a, d);
        ok  = wr && !bad;
        e_tag   = tag;
        e_valid = rd && !bad;
        e_fault = (rd || wr) && bad;
        e_data  = e_valid ? m_read(a) : 64'h0;
        e_self  = ok && a == 12'h83F;
        e_vec   = d[7:0];
        if (ok && a == 12'h808) m_tpr = d[7:0];
        if (ok && a == 12'h830) begin m_icr = d; m_icr[12] = 1'b0; end
        if (ok && a >= 12'h832 && a <= 12'h837) m_lvt[int'(a) - 'h832] = d[31:0];
        m_esr = ((ok && a == 12'h828) ? 8'h0 : m_esr) | el;
    endtask

    task automatic rd(string tag, logic [11:0] a);
        step(tag, 1, 0, a, 64'h0);
    endtask

    task automatic wr(string tag, logic [11:0] a, logic [63:0] d);
        step(tag, 0, 1, a, d);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            isr_vec[32*k +: 32] = 32'hA500_0000 + 32'(k * 32'h0101_0011);
            tmr_vec[32*k +: 32] = 32'h3C00_0F00 ^ 32'(k * 32'h0011_2233);
        end
        for (int k = 0; k < 6; k++) m_lvt[k] = 32'h0001_0000;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // reset state
        step("R1", 0, 0, 12'h0, 64'h0);
        rd("R1", 12'h808); rd("R1", 12'h830); rd("R1", 12'h828);
        rd("R1", 12'h832); rd("R1", 12'h837);
        // identifier, version, logical destination
        rd("R2", 12'h802);
        rd("R11", 12'h803);
        rd("R8", 12'h80D);
        step("R14", 0, 0, 12'h0, 64'h0);
        core_id = 32'hFFFA_B12F;
        rd("R2", 12'h802);
        rd("R8", 12'h80D);
        step("R14", 0, 0, 12'h0, 64'h0);
        core_id = 32'h0000_0010;
        rd("R8", 12'h80D);
        // in-service and trigger-mode slices
        for (int k = 0; k < 8; k++) begin
            rd("R9", 12'h810 + 12'(k));
            rd("R9", 12'h818 + 12'(k));
        end
        // unassigned addresses
        rd("R3", 12'h80E); wr("R3", 12'h80E, 64'h1);
        rd("R3", 12'h800); rd("R3", 12'h820); rd("R3", 12'h8FF);
        rd("R3", 12'h7FF); rd("R3", 12'h900); wr("R3", 12'h838, 64'h5);
        // task priority and vector table
        wr("R10", 12'h808, 64'hFFFF_FF3C);
        rd("R10", 12'h808);
        for (int k = 0; k < 6; k++) wr("R10", 12'h832 + 12'(k), 64'(32'hC0DE_0100 + k * 17));
        for (int k = 0; k < 6; k++) rd("R10", 12'h832 + 12'(k));
        // reserved upper half
        wr("R4", 12'h808, 64'h1_0000_0055);
        rd("R4", 12'h808);
        wr("R4", 12'h834, 64'h8000_0000_0000_0000);
        rd("R4", 12'h834);
        // command register
        wr("R5", 12'h830, 64'hFFFF_FFFF_FFFF_FFFF);
        rd("R5", 12'h830);
        wr("R5", 12'h830, 64'h1234_5678_0000_10AB);
        rd("R5", 12'h830);
        // read-only registers
        wr("R7", 12'h802, 64'h1); wr("R7", 12'h803, 64'h0);
        wr("R7", 12'h80D, 64'h2); wr("R7", 12'h813, 64'h3); wr("R7", 12'h81A, 64'h4);
        rd("R7", 12'h802);
        // self-interrupt port
        wr("R6", 12'h83F, 64'h41);
        wr("R6", 12'h83F, 64'hFE);
        step("R6", 0, 0, 12'h0, 64'h0);
        rd("R6", 12'h83F);
        wr("R6", 12'h83F, 64'h141);
        wr("R6", 12'h83F, 64'h1_0000_0000);
        // error status
        step("R12", 0, 0, 12'h0, 64'h0, 8'h05);
        rd("R12", 12'h828);
        step("R12", 0, 1, 12'h828, 64'h2);
        rd("R12", 12'h828);
        step("R12", 0, 1, 12'h828, 64'h0, 8'h80);
        rd("R12", 12'h828);
        wr("R12", 12'h828, 64'h0);
        rd("R12", 12'h828);
        // both strobes at once
        step("R13", 1, 1, 12'h808, 64'h99);
        rd("R13", 12'h808);
        step("R13", 1, 1, 12'h83F, 64'h22);
        rd("R13", 12'h830);
        step("R14", 0, 0, 12'h0, 64'h0);
        @(negedge clk);
        check_prev();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule